// File: doc/BRIEF.md
# Filtered Input Capture Channel with Holding Register

This block is one input-capture channel of a timer unit. It watches a pin, and when the selected transition appears it copies the current value of an external free-running 16-bit count into its capture register. It then raises a channel flag and, optionally, an interrupt. The pin is first synchronized. It can then pass through a pulse-width rejection filter, so that pulses shorter than 256, 512 or 1024 clocks cause no capture. The channel can also take its edges from a partner pin instead of its own, so that two channels can time the same signal.

A holding register gives the capture a second stage. In latch mode the holding register is loaded from the capture register by a strobe from an external modulus down-counter. That counter, which lies outside this block, raises the strobe when it reaches zero or when zero is written to it. Software can also load the holding register at any time with a force command. In buffered mode every capture shifts the old capture value into the holding register. In two-event mode the flag rises only on every second capture. A no-overwrite option keeps the holding value until software has read it. The flag is cleared either by writing 1 to it or, in fast-clear mode, by reading the capture register.

Top module: `ic_capture_chan`

## Requirements
- R1: After reset the control register reads 0 (edges off, filter off, all options off), the capture and holding registers read 0, and `cap_flag` and `irq` are 0.
- R2: Edge select (control bits 1:0) is 0 = off, 1 = rising, 2 = falling, 3 = either edge. A pin change that does not match the selection causes no capture and leaves the flag at 0.
- R3: On a qualifying edge the capture register (address 1) takes the `count` value present before the rising clock edge N+3 edges after the pin change, where N = 1 with the filter off. The flag is set at that same edge.
- R4: Filter select (control bits 3:2) is 0 = off, 1 = 256, 2 = 512, 3 = 1024 clocks. A synchronized pulse held for N clocks is accepted, and one held for N-1 clocks gives no capture, no flag and an unchanged capture register.
- R5: With latch mode (control bit 4) set, a `latch_stb` pulse copies the capture register into the holding register (address 2), and a single capture sets the flag. With latch mode clear, `latch_stb` has no effect.
- R6: A write of any value to address 2 copies the capture register into the holding register in every mode.
- R7: With holding mode (bit 5) set and latch mode clear, each capture moves the previous capture value into the holding register and sets the flag.
- R8: With latch and holding mode clear and two-event mode (bit 7) set, the flag is set only on the second capture after a control write. The first value is then in the holding register and the second in the capture register.
- R9: With no-overwrite (bit 6) set, once the holding register has been loaded it is not loaded again until it has been read at address 2.
- R10: With share (bit 9) set, edges are taken from `pin_partner`, and changes on `pin_own` cause no capture.
- R11: With fast-clear (bit 8) clear, writing a value with bit 0 = 1 to address 3 clears the flag, and writing 0 leaves it set. With fast-clear set, that write has no effect and a read of address 1 clears the flag.
- R12: `irq` is high exactly when the flag is set and interrupt enable (bit 10) is set.
- R13: The control register reads back its 11 bits at address 0, with bits 15:11 reading 0. Address 3 reads the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_own | input | 1 | Asynchronous pin of this channel |
| pin_partner | input | 1 | Asynchronous pin of the partner channel |
| count | input | 16 | Free-running counter value |
| latch_stb | input | 1 | One-cycle strobe from the modulus down-counter |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable (read side effects) |
| reg_addr | input | 2 | Register address: 0 control, 1 capture, 2 holding, 3 flag |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |
| cap_flag | output | 1 | Channel flag |
| irq | output | 1 | Interrupt request |

## Verification
A pin change reaches the capture register and the flag N+3 rising edges later: two synchronizer stages, N filter cycles (one when the filter is off) and the edge-detect stage. The bench reads the counter at the falling edge where it moves the pin, and the expected capture is that value plus N+2. It waits several cycles past that edge before it compares. Register writes, force latch and latch strobes act at the next rising edge, and reads return data in the same cycle. For this reason every compare is made at a falling edge after the edge that applies the write or strobe. Filter acceptance is tested at pulse widths of exactly N and N-1 cycles.

// File: rtl/ic_pkg.sv
// Shared types for the input capture channel.
// Assumes a 2-bit register address space and an 11-bit control word.
package ic_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_t;

    typedef struct packed {
        logic       irq_en;   // bit 10
        logic       share;    // bit 9
        logic       fast_clr; // bit 8
        logic       two_ev;   // bit 7
        logic       no_ovw;   // bit 6
        logic       hold_en;  // bit 5
        logic       latch_en; // bit 4
        logic [1:0] dly;      // bits 3:2
        edge_sel_t  edge_sel; // bits 1:0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CAP  = 2'd1;
    localparam logic [1:0] ADDR_HOLD = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;
endpackage

// File: rtl/ic_filter.sv
// Two-flop synchronizer followed by a pulse-width rejection filter.
// The output level follows the synchronized pin only after the pin has
// differed from the output for the selected number of clocks. Any return
// to the output level restarts the count. Select 0 passes the level after
// one clock.
// Assumes DLY_BASE >= 1. The longest delay is 4*DLY_BASE.
module ic_filter #(
    parameter int DLY_BASE = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_raw,
    input  logic [1:0] dly_sel,
    output logic       lvl
);
    localparam int CW = $clog2(4 * DLY_BASE) + 1;

    logic          sync1, sync2;
    logic [CW-1:0] fcnt;
    logic [CW-1:0] lim;

    // Two-stage synchronizer for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= pin_raw;
            sync2 <= sync1;
        end
    end

    // Terminal count for the selected delay.
    always_comb begin
        case (dly_sel)
            2'd1:    lim = CW'(DLY_BASE - 1);
            2'd2:    lim = CW'(2 * DLY_BASE - 1);
            2'd3:    lim = CW'(4 * DLY_BASE - 1);
            default: lim = '0;
        endcase
    end

    // Stability counter: accept the new level after lim+1 differing cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt <= '0;
            lvl  <= 1'b0;
        end else if (sync2 == lvl) begin
            fcnt <= '0;
        end else if (fcnt >= lim) begin
            fcnt <= '0;
            lvl  <= sync2;
        end else begin
            fcnt <= fcnt + 1'b1;
        end
    end
endmodule

// File: rtl/ic_edge.sv
// Edge qualifier: compares the filtered level with its previous value
// and raises a one-cycle event for the selected transition.
// Assumes the level is already synchronous to clk.
module ic_edge
    import ic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  edge_sel_t edge_sel,
    output logic      ev
);
    logic lvl_q;

    // Previous level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // Match the transition against the edge selection.
    always_comb begin
        case (edge_sel)
            EDGE_RISE: ev = lvl & ~lvl_q;
            EDGE_FALL: ev = ~lvl & lvl_q;
            EDGE_ANY:  ev = lvl ^ lvl_q;
            default:   ev = 1'b0;
        endcase
    end
endmodule

// File: rtl/ic_hold.sv
// Capture register, holding register and channel flag.
// A capture stores the count. The holding register loads from the
// capture register on a latch strobe (latch mode), on a force command, or
// on each capture (buffered or two-event mode). No-overwrite blocks a
// load while an unread value is held. A flag set wins over a clear in
// the same cycle.
// Assumes all control inputs are single-cycle pulses.
module ic_hold
    import ic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             ctrl_wr,
    input  logic             ev,
    input  logic [CNT_W-1:0] count,
    input  logic             latch_stb,
    input  logic             force_ld,
    input  logic             hold_rd,
    input  logic             cap_rd,
    input  logic             flag_w1c,
    output logic [CNT_W-1:0] cap_val,
    output logic [CNT_W-1:0] hold_val,
    output logic             hold_full,
    output logic             flag
);
    logic shift_mode, two_mode, hold_ok, hold_ld, pend, flag_set, flag_clr;

    assign shift_mode = !ctrl.latch_en && (ctrl.hold_en || ctrl.two_ev);
    assign two_mode   = !ctrl.latch_en && !ctrl.hold_en && ctrl.two_ev;
    assign hold_ok    = !(ctrl.no_ovw && hold_full);
    assign hold_ld    = hold_ok && ((ev && shift_mode) || force_ld ||
                                    (latch_stb && ctrl.latch_en));
    assign flag_set   = ev && (!two_mode || pend);
    assign flag_clr   = ctrl.fast_clr ? cap_rd : flag_w1c;

    // Capture register: take the count on each qualified event.
    always_ff @(posedge clk) begin
        if (!rst_n)  cap_val <= '0;
        else if (ev) cap_val <= count;
    end

    // Holding register and its unread marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_val  <= '0;
            hold_full <= 1'b0;
        end else if (hold_ld) begin
            hold_val  <= cap_val;
            hold_full <= 1'b1;
        end else if (hold_rd) begin
            hold_full <= 1'b0;
        end
    end

    // Two-event phase: restarts on any control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend <= 1'b0;
        else if (ctrl_wr)          pend <= 1'b0;
        else if (ev && two_mode)   pend <= !pend;
    end

    // Channel flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/ic_capture_chan.sv
// Top of the input capture channel: register decode, own/partner pin
// filters, edge qualifier and capture/holding logic.
// Assumes count is synchronous to clk and latch_stb is one cycle wide.
module ic_capture_chan
    import ic_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DLY_BASE = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_own,
    input  logic             pin_partner,
    input  logic [CNT_W-1:0] count,
    input  logic             latch_stb,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             cap_flag,
    output logic             irq
);
    localparam int NPIN = 2;

    ctrl_t            ctrl_q;
    logic [NPIN-1:0]  pins, lvls;
    logic             src_lvl, cap_ev, ctrl_wr;
    logic [CNT_W-1:0] cap_val, hold_val;
    logic             hold_full;

    assign pins    = {pin_partner, pin_own};
    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    // One filter per candidate pin.
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        ic_filter #(.DLY_BASE(DLY_BASE)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (pins[i]),
            .dly_sel (ctrl_q.dly),
            .lvl     (lvls[i])
        );
    end

    assign src_lvl = ctrl_q.share ? lvls[1] : lvls[0];

    ic_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (src_lvl),
        .edge_sel (ctrl_q.edge_sel),
        .ev       (cap_ev)
    );

    ic_hold #(.CNT_W(CNT_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl_q),
        .ctrl_wr   (ctrl_wr),
        .ev        (cap_ev),
        .count     (count),
        .latch_stb (latch_stb),
        .force_ld  (reg_wr && (reg_addr == ADDR_HOLD)),
        .hold_rd   (reg_rd && (reg_addr == ADDR_HOLD)),
        .cap_rd    (reg_rd && (reg_addr == ADDR_CAP)),
        .flag_w1c  (reg_wr && (reg_addr == ADDR_FLAG) && reg_wdata[0]),
        .cap_val   (cap_val),
        .hold_val  (hold_val),
        .hold_full (hold_full),
        .flag      (cap_flag)
    );

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            ADDR_CAP:  reg_rdata = 16'(cap_val);
            ADDR_HOLD: reg_rdata = 16'(hold_val);
            default:   reg_rdata[0] = cap_flag;
        endcase
    end

    assign irq = cap_flag && ctrl_q.irq_en;
endmodule

// File: rtl/ic_capture_chk.sv
// Assertion checker for ic_capture_chan, attached by bind.
module ic_capture_chk
    import ic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input ctrl_t            ctrl_q,
    input logic             cap_ev,
    input logic [CNT_W-1:0] cap_val,
    input logic [CNT_W-1:0] hold_val,
    input logic             hold_full,
    input logic             cap_flag,
    input logic             irq,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr
);
    AST_EDGE_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.edge_sel == EDGE_OFF |-> !cap_ev); // R2

    AST_CAP_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_ev |=> $stable(cap_val)); // R3

    AST_SINGLE_EVENT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev && !(ctrl_q.two_ev && !ctrl_q.latch_en && !ctrl_q.hold_en)
        |=> cap_flag); // R5

    AST_NO_OVERWRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.no_ovw && hold_full |=> $stable(hold_val)); // R9

    AST_FASTCLR_W1C_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.fast_clr && cap_flag && reg_wr && reg_addr == ADDR_FLAG && !reg_rd
        |=> cap_flag); // R11

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cap_flag && ctrl_q.irq_en); // R12
endmodule

bind ic_capture_chan ic_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_q    (ctrl_q),
    .cap_ev    (cap_ev),
    .cap_val   (cap_val),
    .hold_val  (hold_val),
    .hold_full (hold_full),
    .cap_flag  (cap_flag),
    .irq       (irq),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr)
);

// File: tb/tb_ic_capture_chan.sv
// Self-checking bench for ic_capture_chan.
module tb_ic_capture_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_own = 1'b0, pin_partner = 1'b0;
    logic [15:0] tcount = '0;
    logic        latch_stb = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cap_flag, irq;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    bit lvl_own = 0, lvl_par = 0;

    ic_capture_chan dut (
        .clk(clk), .rst_n(rst_n), .pin_own(pin_own), .pin_partner(pin_partner),
        .count(tcount), .latch_stb(latch_stb), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cap_flag(cap_flag), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) tcount <= tcount + 16'd1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int es, input int dly, input bit latch,
                                       input bit hold, input bit noovw, input bit two,
                                       input bit fast, input bit share, input bit ien);
        logic [15:0] v;
        v = '0;
        v[1:0] = 2'(es); v[3:2] = 2'(dly); v[4] = latch; v[5] = hold; v[6] = noovw;
        v[7] = two; v[8] = fast; v[9] = share; v[10] = ien;
        return v;
    endfunction

    function automatic int nof(input int sel);
        return (sel == 0) ? 1 : (256 << (sel - 1));
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic strobe();
        @(negedge clk); latch_stb = 1;
        @(negedge clk); latch_stb = 0;
    endtask

    // Toggle a pin and return the count value the capture must hold.
    task automatic tog(input int which, input int n, output logic [15:0] expv);
        @(negedge clk);
        expv = tcount + 16'(2 + n);
        if (which == 0) begin lvl_own = !lvl_own; pin_own = lvl_own; end
        else            begin lvl_par = !lvl_par; pin_partner = lvl_par; end
        repeat (n + 8) @(negedge clk);
    endtask

    // High pulse of w cycles on the own pin.
    task automatic pulse(input int w, input int n, output logic [15:0] expv);
        @(negedge clk);
        expv = tcount + 16'(2 + n);
        pin_own = 1;
        repeat (w) @(negedge clk);
        pin_own = 0;
        repeat (2 * n + 10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, old, x1, x2, x3, x4, x5, x6, x7, x8;
        bit hit;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(0, d); chk("R1 ctrl", d, 0);
        rd(1, d); chk("R1 cap", d, 0);
        rd(2, d); chk("R1 hold", d, 0);
        chk("R1 flag", cap_flag, 0);
        chk("R1 irq", irq, 0);

        // R2 R3 R10 sweep: edge select x direction x pin source
        for (int sh = 0; sh < 2; sh++) begin
            for (int es = 0; es < 4; es++) begin
                wr(0, mk(es, 0, 0, 0, 0, 0, 0, sh[0], 0));
                for (int dir = 0; dir < 2; dir++) begin
                    wr(3, 16'h1);
                    rd(1, old);
                    tog(sh, 1, x1);
                    hit = (es == 3) || (es == 1 && dir == 0) || (es == 2 && dir == 1);
                    chk($sformatf("R2 flag sh=%0d es=%0d dir=%0d", sh, es, dir), cap_flag, hit);
                    rd(1, d);
                    chk($sformatf("R3 cap sh=%0d es=%0d dir=%0d", sh, es, dir), d, hit ? x1 : old);
                end
            end
        end

        // R10 own pin ignored while sharing
        wr(0, mk(3, 0, 0, 0, 0, 0, 0, 1, 0));
        wr(3, 16'h1);
        tog(0, 1, x1);
        chk("R10 own pin ignored", cap_flag, 0);
        wr(0, mk(0, 0, 0, 0, 0, 0, 0, 1, 0));
        tog(0, 1, x1);

        // R4 filter boundaries
        for (int sel = 1; sel < 4; sel++) begin
            wr(0, mk(1, sel, 0, 0, 0, 0, 0, 0, 0));
            wr(3, 16'h1);
            rd(1, old);
            pulse(nof(sel) - 1, nof(sel), x1);
            chk($sformatf("R4 short flag sel=%0d", sel), cap_flag, 0);
            rd(1, d); chk($sformatf("R4 short cap sel=%0d", sel), d, old);
            pulse(nof(sel), nof(sel), x1);
            chk($sformatf("R4 full flag sel=%0d", sel), cap_flag, 1);
            rd(1, d); chk($sformatf("R4 full cap sel=%0d", sel), d, x1);
        end

        // R5 latch mode
        wr(0, mk(1, 0, 1, 0, 0, 0, 0, 0, 0));
        wr(3, 16'h1);
        tog(0, 1, x1);
        chk("R5 single event flag", cap_flag, 1);
        strobe();
        rd(2, d); chk("R5 strobe loads hold", d, x1);

        // R6 force latch, R5 strobe ignored without latch mode
        wr(0, mk(3, 0, 0, 0, 0, 0, 0, 0, 0));
        tog(0, 1, x2);
        wr(2, 16'h0);
        rd(2, d); chk("R6 force latch", d, x2);
        tog(0, 1, x3);
        strobe();
        rd(2, d); chk("R5 strobe ignored", d, x2);

        // R9 no-overwrite
        wr(0, mk(3, 0, 1, 0, 1, 0, 0, 0, 0));
        strobe();
        tog(0, 1, x4);
        strobe();
        rd(2, d); chk("R9 hold kept", d, x3);
        strobe();
        rd(2, d); chk("R9 reload after read", d, x4);

        // R7 buffered mode
        wr(0, mk(3, 0, 0, 1, 0, 0, 0, 0, 0));
        wr(3, 16'h1);
        tog(0, 1, x5);
        chk("R7 flag first event", cap_flag, 1);
        tog(0, 1, x6);
        rd(1, d); chk("R7 cap", d, x6);
        rd(2, d); chk("R7 hold", d, x5);

        // R8 two-event mode
        wr(0, mk(3, 0, 0, 0, 0, 1, 0, 0, 0));
        wr(3, 16'h1);
        tog(0, 1, x7);
        chk("R8 no flag after first", cap_flag, 0);
        tog(0, 1, x8);
        chk("R8 flag after second", cap_flag, 1);
        rd(1, d); chk("R8 cap second", d, x8);
        rd(2, d); chk("R8 hold first", d, x7);

        // R11 fast clear
        wr(0, mk(3, 0, 0, 0, 0, 0, 1, 0, 0));
        wr(3, 16'h1);
        chk("R11 w1c ignored in fast clear", cap_flag, 1);
        rd(1, d);
        chk("R11 read clears", cap_flag, 0);
        wr(0, mk(3, 0, 0, 0, 0, 0, 0, 0, 0));
        tog(0, 1, x1);
        wr(3, 16'h0);
        chk("R11 write 0 keeps flag", cap_flag, 1);
        rd(1, d);
        chk("R11 read no clear", cap_flag, 1);
        wr(3, 16'h1);
        chk("R11 write 1 clears", cap_flag, 0);

        // R12 interrupt gating
        wr(0, mk(3, 0, 0, 0, 0, 0, 0, 0, 1));
        chk("R12 irq low no flag", irq, 0);
        tog(0, 1, x1);
        chk("R12 irq high", irq, 1);
        wr(0, mk(3, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R12 irq masked", irq, 0);

        // R13 readback
        rd(3, d); chk("R13 flag read", d, 16'h1);
        wr(0, 16'hFFFF);
        rd(0, d); chk("R13 ctrl readback", d, 16'h07FF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule